// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block collects up to 32 level-sensitive interrupt request lines from peripherals and drives two outputs to a processor core: a combined normal interrupt line and a separate fast-interrupt line. Each request line is placed in the fast class or the normal class by a per-source select bit, and a global enable mask gates every line. Software can force any request line active through a set of software request bits.

Sixteen vectored slots sit in the normal class. Each slot holds a source number, a slot enable bit and a handler address, and any slot can be bound to any source. Slot 0 has the highest priority and slot 15 the lowest. When the interrupt handler reads the vector register, it gets the handler address of the highest-priority competing slot. If no slot is competing, it gets a single shared default address. That value is latched on the first read and stays latched until software writes the vector register to mark the end of service. Status registers show the request lines before masking and the masked lines for each class, so the default handler can find the source.

The register bus is a simple single-cycle port. Read data is combinational from the selected register. Writes take effect at the next rising clock edge.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, these are all zero: the enable mask, the class select, the software requests, the default address and every slot's source, enable and address. `irqOut` and `fiqOut` are low, and a vector read returns 0.
- R2: Writing word 0x04 sets the enable bits where the written data has ones. Writing word 0x05 clears them. Reading either word returns the enable mask.
- R3: `irqOut` is the OR of raw & enable & ~classSelect. Reading word 0x00 returns that masked vector, with bit n for source n.
- R4: Word 0x03 holds the class select, where 1 means fast. `fiqOut` is the OR of raw & enable & classSelect, and word 0x01 reads that masked vector. A fast-class source never drives `irqOut` and never takes part in slot arbitration.
- R5: Reading word 0x02 returns the raw request vector, which is `intReq` OR the software request bits, before any masking.
- R6: Writing word 0x06 sets software request bits, and writing word 0x07 clears them. Reading either word returns the software request bits.
- R7: The control word of slot n is at 0x20+n: bits 4:0 hold the source number and bit 5 is the slot enable. A slot competes only when its enable bit is set and its source is active, enabled and in the normal class.
- R8: When several slots compete, the lowest-numbered one wins. A vector read (word 0x08) returns that slot's handler address, which is stored at word 0x10+n.
- R9: When no slot competes, a vector read returns the default address stored at word 0x09.
- R10: The first vector read captures the returned address. Later vector reads return the same value, even if the requests change, until software writes word 0x08. The next read after that write captures a new address.
- R11: Reads of unmapped words return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| intReq | input | 32 | Level-sensitive request lines, bit n is source n |
| busSel | input | 1 | Register access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| irqOut | output | 1 | Combined normal-class interrupt |
| fiqOut | output | 1 | Fast-class interrupt |

## Verification
The outputs `irqOut` and `fiqOut`, and the read data of every status and vector word, are combinational. They follow `intReq` and the register contents in the same cycle, with no register in the path. A bus write has its effect from the next rising edge, and a vector capture takes effect at the edge that ends the read cycle. The bench drives each access just after a falling edge and compares against its model 1 ns later, inside the same cycle. It updates the model only at the following rising edge, so each result is checked in the exact cycle it becomes due. Both interrupt outputs are compared in every bus or idle cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // word offsets inside the low region (upper address nibble zero)
  localparam logic [3:0] OFS_IRQ_STAT  = 4'h0;
  localparam logic [3:0] OFS_FIQ_STAT  = 4'h1;
  localparam logic [3:0] OFS_RAW_STAT  = 4'h2;
  localparam logic [3:0] OFS_CLASS     = 4'h3;
  localparam logic [3:0] OFS_EN_SET    = 4'h4;
  localparam logic [3:0] OFS_EN_CLR    = 4'h5;
  localparam logic [3:0] OFS_SOFT_SET  = 4'h6;
  localparam logic [3:0] OFS_SOFT_CLR  = 4'h7;
  localparam logic [3:0] OFS_VECTOR    = 4'h8;
  localparam logic [3:0] OFS_DEFAULT   = 4'h9;

  // upper nibble codes of the per-slot regions
  localparam int REGION_LOW       = 0;
  localparam int REGION_SLOT_ADDR = 1;
  localparam int REGION_SLOT_CTRL = 2;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_IRQ,
    RD_FIQ,
    RD_RAW,
    RD_CLASS,
    RD_EN,
    RD_SOFT,
    RD_VEC,
    RD_DEF,
    RD_SLOT_ADDR,
    RD_SLOT_CTRL
  } rdSrc_e;

  typedef struct packed {
    logic   wrClass;
    logic   wrEnSet;
    logic   wrEnClr;
    logic   wrSoftSet;
    logic   wrSoftClr;
    logic   wrDef;
    logic   wrSlotAddr;
    logic   wrSlotCtrl;
    logic   capVec;
    logic   useHeld;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  localparam int HI_W = ADDR_W - 4;

  logic            isRd;
  logic            isWr;
  logic [HI_W-1:0] hiNib;
  logic [3:0]      loNib;
  logic            slotOk;
  logic            vecHit;
  logic            held;

  assign isRd   = busSel && !busWr;
  assign isWr   = busSel && busWr;
  assign hiNib  = busAddr[ADDR_W-1:4];
  assign loNib  = busAddr[3:0];
  assign slotOk = int'(loNib) < NUM_SLOT;
  assign vecHit = (hiNib == HI_W'(REGION_LOW)) && (loNib == OFS_VECTOR);

  // service state: set by the capturing read, cleared by end-of-service write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= 1'b0;
    end else if (isWr && vecHit) begin
      held <= 1'b0;
    end else if (isRd && vecHit) begin
      held <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSrc   = RD_NONE;
    strobe.useHeld = held;
    if (hiNib == HI_W'(REGION_SLOT_ADDR)) begin
      if (slotOk) begin
        strobe.rdSrc      = RD_SLOT_ADDR;
        strobe.wrSlotAddr = isWr;
      end
    end else if (hiNib == HI_W'(REGION_SLOT_CTRL)) begin
      if (slotOk) begin
        strobe.rdSrc      = RD_SLOT_CTRL;
        strobe.wrSlotCtrl = isWr;
      end
    end else if (hiNib == HI_W'(REGION_LOW)) begin
      case (loNib)
        OFS_IRQ_STAT: strobe.rdSrc = RD_IRQ;
        OFS_FIQ_STAT: strobe.rdSrc = RD_FIQ;
        OFS_RAW_STAT: strobe.rdSrc = RD_RAW;
        OFS_CLASS: begin
          strobe.rdSrc   = RD_CLASS;
          strobe.wrClass = isWr;
        end
        OFS_EN_SET: begin
          strobe.rdSrc   = RD_EN;
          strobe.wrEnSet = isWr;
        end
        OFS_EN_CLR: begin
          strobe.rdSrc   = RD_EN;
          strobe.wrEnClr = isWr;
        end
        OFS_SOFT_SET: begin
          strobe.rdSrc     = RD_SOFT;
          strobe.wrSoftSet = isWr;
        end
        OFS_SOFT_CLR: begin
          strobe.rdSrc     = RD_SOFT;
          strobe.wrSoftClr = isWr;
        end
        OFS_VECTOR: begin
          strobe.rdSrc  = RD_VEC;
          strobe.capVec = isRd && !held;
        end
        OFS_DEFAULT: begin
          strobe.rdSrc = RD_DEF;
          strobe.wrDef = isWr;
        end
        default: strobe.rdSrc = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          intReq,
  input  logic [$clog2(NUM_SLOT)-1:0] slotIdx,
  input  logic [DATA_W-1:0]           busWdata,
  input  ctrlStrobe_t                 strobe,
  output logic [DATA_W-1:0]           busRdata,
  output logic                        irqOut,
  output logic                        fiqOut
);

  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int SLOT_W  = $clog2(NUM_SLOT);
  localparam int CTRL_EN = SRC_W;

  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] classSel;
  logic [NUM_SRC-1:0] softReq;
  logic [DATA_W-1:0]  defAddr;
  logic [DATA_W-1:0]  heldAddr;
  logic [DATA_W-1:0]  liveAddr;

  logic [NUM_SRC-1:0] rawReq;
  logic [NUM_SRC-1:0] irqAct;
  logic [NUM_SRC-1:0] fiqAct;

  logic [DATA_W-1:0]  slotAddr [NUM_SLOT];
  logic [SRC_W-1:0]   slotSrc  [NUM_SLOT];
  logic               slotEn   [NUM_SLOT];
  logic [NUM_SLOT-1:0] slotHit;

  logic [NUM_SRC-1:0] wdSrc;
  assign wdSrc = busWdata[NUM_SRC-1:0];

  // per-source masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask   <= '0;
      classSel <= '0;
      softReq  <= '0;
      defAddr  <= '0;
    end else begin
      if (strobe.wrEnSet)   enMask   <= enMask | wdSrc;
      if (strobe.wrEnClr)   enMask   <= enMask & ~wdSrc;
      if (strobe.wrSoftSet) softReq  <= softReq | wdSrc;
      if (strobe.wrSoftClr) softReq  <= softReq & ~wdSrc;
      if (strobe.wrClass)   classSel <= wdSrc;
      if (strobe.wrDef)     defAddr  <= busWdata;
    end
  end

  assign rawReq = intReq | softReq;
  assign irqAct = rawReq & enMask & ~classSel;
  assign fiqAct = rawReq & enMask & classSel;
  assign irqOut = |irqAct;
  assign fiqOut = |fiqAct;

  // slot storage and per-slot request test
  for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[g] <= '0;
        slotSrc[g]  <= '0;
        slotEn[g]   <= 1'b0;
      end else begin
        if (strobe.wrSlotAddr && (slotIdx == SLOT_W'(g))) begin
          slotAddr[g] <= busWdata;
        end
        if (strobe.wrSlotCtrl && (slotIdx == SLOT_W'(g))) begin
          slotSrc[g] <= busWdata[SRC_W-1:0];
          slotEn[g]  <= busWdata[CTRL_EN];
        end
      end
    end
    assign slotHit[g] = slotEn[g] && irqAct[slotSrc[g]];
  end

  // fixed priority: walk from the lowest priority up so slot 0 is applied last
  always_comb begin
    liveAddr = defAddr;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (slotHit[i]) liveAddr = slotAddr[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
    end else if (strobe.capVec) begin
      heldAddr <= liveAddr;
    end
  end

  always_comb begin
    busRdata = '0;
    case (strobe.rdSrc)
      RD_IRQ:       busRdata[NUM_SRC-1:0] = irqAct;
      RD_FIQ:       busRdata[NUM_SRC-1:0] = fiqAct;
      RD_RAW:       busRdata[NUM_SRC-1:0] = rawReq;
      RD_CLASS:     busRdata[NUM_SRC-1:0] = classSel;
      RD_EN:        busRdata[NUM_SRC-1:0] = enMask;
      RD_SOFT:      busRdata[NUM_SRC-1:0] = softReq;
      RD_VEC:       busRdata = strobe.useHeld ? heldAddr : liveAddr;
      RD_DEF:       busRdata = defAddr;
      RD_SLOT_ADDR: busRdata = slotAddr[slotIdx];
      RD_SLOT_CTRL: begin
        busRdata[SRC_W-1:0] = slotSrc[slotIdx];
        busRdata[CTRL_EN]   = slotEn[slotIdx];
      end
      default:      busRdata = '0;
    endcase
  end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] intReq,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int SLOT_W = $clog2(NUM_SLOT);

  ctrlStrobe_t strobe;

  intc_ctrl #(
    .NUM_SLOT(NUM_SLOT),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  intc_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_SLOT(NUM_SLOT),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .intReq  (intReq),
    .slotIdx (busAddr[SLOT_W-1:0]),
    .busWdata(busWdata),
    .strobe  (strobe),
    .busRdata(busRdata),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] intReq,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busRdata,
  input logic               irqOut,
  input logic               fiqOut
);

  logic rdIrqStat, rdFiqStat, rdRaw, rdVec;
  assign rdIrqStat = busSel && !busWr && (busAddr == ADDR_W'(8'h00));
  assign rdFiqStat = busSel && !busWr && (busAddr == ADDR_W'(8'h01));
  assign rdRaw     = busSel && !busWr && (busAddr == ADDR_W'(8'h02));
  assign rdVec     = busSel && !busWr && (busAddr == ADDR_W'(8'h08));

  // R1: masks are clear when reset is released, so both outputs are low
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && !fiqOut));

  // R3: normal-class status nonzero exactly when irqOut is high
  a_r3_irq_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    rdIrqStat |-> ((busRdata != '0) == irqOut));

  // R4: fast-class status nonzero exactly when fiqOut is high
  a_r4_fiq_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    rdFiqStat |-> ((busRdata != '0) == fiqOut));

  // R5: raw status always covers every hardware line that is high
  a_r5_raw_covers_lines: assert property (@(posedge clk) disable iff (!rstN)
    rdRaw |-> ((busRdata[NUM_SRC-1:0] & intReq) == intReq));

  // R10: back-to-back vector reads return the same captured value
  a_r10_vector_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && $past(rdVec)) |-> (busRdata == $past(busRdata)));

endmodule

bind prio_vec_intc prio_vec_intc_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .intReq  (intReq),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] intReq = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prio_vec_intc u_prio_vec_intc (
    .clk(clk), .rstN(rstN), .intReq(intReq), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // behavioural reference state
  bit [31:0] mEn, mSel, mSoft, mDef, mHeldAddr;
  bit [31:0] mSlotAddr [16];
  int        mSlotSrc  [16];
  bit        mSlotEn   [16];
  bit        mHeld;

  function automatic bit [31:0] mRaw();
    return intReq | mSoft;
  endfunction

  function automatic bit [31:0] mIrqVec();
    return mRaw() & mEn & ~mSel;
  endfunction

  function automatic bit [31:0] mFiqVec();
    return mRaw() & mEn & mSel;
  endfunction

  function automatic bit [31:0] mLive();
    bit [31:0] act = mIrqVec();
    for (int n = 0; n < 16; n++) begin
      if (mSlotEn[n] && act[mSlotSrc[n]]) return mSlotAddr[n];
    end
    return mDef;
  endfunction

  function automatic bit [31:0] mRead(input bit [7:0] a);
    if (a[7:4] == 4'h1) return mSlotAddr[a[3:0]];
    if (a[7:4] == 4'h2) return {26'b0, mSlotEn[a[3:0]], 5'(mSlotSrc[a[3:0]])};
    case (a)
      8'h00: return mIrqVec();
      8'h01: return mFiqVec();
      8'h02: return mRaw();
      8'h03: return mSel;
      8'h04, 8'h05: return mEn;
      8'h06, 8'h07: return mSoft;
      8'h08: return mHeld ? mHeldAddr : mLive();
      8'h09: return mDef;
      default: return 32'h0;
    endcase
  endfunction

  task automatic mApply(input bit wr, input bit [7:0] a, input bit [31:0] wd);
    if (wr) begin
      if (a[7:4] == 4'h1) mSlotAddr[a[3:0]] = wd;
      else if (a[7:4] == 4'h2) begin
        mSlotSrc[a[3:0]] = int'(wd[4:0]);
        mSlotEn[a[3:0]]  = wd[5];
      end else begin
        case (a)
          8'h03: mSel  = wd;
          8'h04: mEn   = mEn | wd;
          8'h05: mEn   = mEn & ~wd;
          8'h06: mSoft = mSoft | wd;
          8'h07: mSoft = mSoft & ~wd;
          8'h08: mHeld = 1'b0;
          8'h09: mDef  = wd;
          default: ;
        endcase
      end
    end else if (a == 8'h08 && !mHeld) begin
      mHeldAddr = mLive();
      mHeld     = 1'b1;
    end
  endtask

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    check({tag, " irqOut"}, {31'b0, irqOut}, {31'b0, mIrqVec() != 0});
    check({tag, " fiqOut"}, {31'b0, fiqOut}, {31'b0, mFiqVec() != 0});
  endtask

  // one bus cycle: drive after the falling edge, compare 1 ns later, model at rising edge
  task automatic busOp(input bit wr, input bit [7:0] a, input bit [31:0] wd, input string tag);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = wd;
    #1;
    if (!wr) check(tag, busRdata, mRead(a));
    checkOuts(tag);
    @(posedge clk);
    mApply(wr, a, wd);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, input string tag);
    busOp(1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] wd, input string tag);
    busOp(1'b1, a, wd, tag);
  endtask

  task automatic idle(input string tag);
    busSel = 1'b0;
    #1;
    checkOuts(tag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) begin
      mSlotAddr[n] = '0; mSlotSrc[n] = 0; mSlotEn[n] = 1'b0;
    end
    mEn = '0; mSel = '0; mSoft = '0; mDef = '0; mHeld = 1'b0; mHeldAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    idle("R1 idle");
    rd(8'h04, "R1 enable");
    rd(8'h03, "R1 class");
    rd(8'h09, "R1 default");
    rd(8'h23, "R1 slot ctrl");
    rd(8'h15, "R1 slot addr");
    rd(8'h08, "R1 vector");
    wr(8'h08, 32'h0, "R10 end");

    // R5: raw lines visible before any enable
    intReq = 32'h0000_00F0;
    rd(8'h02, "R5 raw");
    rd(8'h00, "R3 masked none");

    // R2 enable set/clear
    wr(8'h04, 32'h0000_0030, "R2 set");
    rd(8'h05, "R2 mask after set");
    rd(8'h00, "R3 status");
    wr(8'h05, 32'h0000_0010, "R2 clear");
    rd(8'h04, "R2 mask after clear");

    // R6 software request
    wr(8'h06, 32'h0000_0001, "R6 soft set");
    rd(8'h02, "R5 raw with soft");
    rd(8'h07, "R6 soft read");
    wr(8'h04, 32'h0000_0001, "R2 set bit0");
    rd(8'h00, "R3 status two");

    // R4 fast class
    wr(8'h03, 32'h0000_0020, "R4 class");
    rd(8'h01, "R4 fast status");
    rd(8'h00, "R4 normal status");

    // slots
    wr(8'h09, 32'hDEF0_0000, "R9 default");
    wr(8'h13, 32'h0000_3000, "R8 slot3 addr");
    wr(8'h23, 32'h0000_0020, "R7 slot3 ctrl");
    wr(8'h17, 32'h0000_7000, "R8 slot7 addr");
    wr(8'h27, 32'h0000_0025, "R7 slot7 ctrl");
    wr(8'h19, 32'h0000_9000, "R8 slot9 addr");
    wr(8'h29, 32'h0000_0024, "R7 slot9 ctrl");
    rd(8'h27, "R7 ctrl readback");

    // R8: slot3 on source 0 wins; slot7 source is fast, slot9 source disabled
    rd(8'h08, "R8 vector slot3");
    wr(8'h07, 32'h0000_0001, "R6 soft clear");
    rd(8'h08, "R10 still held");
    rd(8'h00, "R3 status none");
    wr(8'h08, 32'h0, "R10 end");
    rd(8'h08, "R9 default vector");
    wr(8'h08, 32'h0, "R10 end");

    // R4 back to normal: slot7 competes now
    wr(8'h03, 32'h0, "R4 class clear");
    rd(8'h08, "R4 slot7 vector");
    wr(8'h08, 32'h0, "R10 end");

    // R7: enable source 4 so slot9 competes but slot7 outranks it
    wr(8'h04, 32'h0000_0010, "R2 set bit4");
    rd(8'h08, "R8 slot7 over slot9");
    wr(8'h08, 32'h0, "R10 end");
    wr(8'h27, 32'h0000_0005, "R7 slot7 off");
    rd(8'h08, "R7 slot9 vector");
    intReq = 32'h0000_0000;
    rd(8'h08, "R10 held after lines drop");
    wr(8'h08, 32'h0, "R10 end");
    wr(8'h06, 32'h0000_0001, "R6 soft again");
    rd(8'h08, "R8 slot3 again");
    wr(8'h08, 32'h0, "R10 end");

    // R11 unmapped
    rd(8'h3F, "R11 unmapped read");
    wr(8'h0A, 32'hFFFF_FFFF, "R11 unmapped write");
    wr(8'h1F, 32'h0000_0000, "R11 slot15 write");
    rd(8'h04, "R11 enable unchanged");
    rd(8'h09, "R11 default unchanged");
    idle("R3 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule